// File: doc/BRIEF.md
# Translation-Cache Invalidation Command Decoder

This block sits between a command-queue reader and a tagged address-translation cache. It accepts one 128-bit command at a time, made of two 64-bit dwords, on a valid/ready port. If the command carries the invalidation opcode, the block turns it into a short sequence of invalidation requests for the cache. Each request carries a match mode, a guest context ID, a process context ID, a page-aligned address and a translation tag. The tag says which kind of cached mapping the request may touch: single-stage, guest-stage-only or nested.

There are two invalidation functions:

- The virtual-address function produces one request.
- The guest-physical function produces two requests back to back. The first carries the guest-stage-only tag and the second the nested tag.

A command with an illegal field combination is flagged and consumed without producing a request. A command with any other opcode is consumed at once and reported on a separate flag, so that a neighbouring decoder can take it. The command stays held, with `cmd_ready` low, until the cache has accepted every request it produces.

Top module: `tlbinv_cmd_decoder`

## Requirements
- R1: A command is claimed only when dw0[6:0] equals `INV_OPCODE` (default 1). Any other opcode raises `other_op` and `cmd_ready` in the same cycle, with `req_valid` and `illegal` low.
- R2: The function code is dw0[9:7]. Value 0 selects the virtual-address function and value 1 the guest-physical function. Any other value raises `illegal` and `cmd_ready` with no request.
- R3: A guest-physical command with the process-ID-valid flag (dw0[32]) set raises `illegal` and `cmd_ready` in the same cycle and issues no request.
- R4: The match mode is a 3-bit value: bit 2 matches the guest ID, bit 1 the address, bit 0 the process ID. Let the guest-valid flag be dw0[33] and the address-valid flag dw0[10]. For the guest-physical function the mode is 0 when guest-valid is clear (address-valid is then ignored), 4 when only guest-valid is set, and 6 when both are set.
- R5: A legal guest-physical command issues exactly two requests with identical mode and fields. The first carries tag 2 (guest-stage only) and the second tag 3 (nested).
- R6: A virtual-address command with guest-valid set issues one request with tag 3. Its mode is {1, address-valid, process-ID-valid}.
- R7: A virtual-address command with guest-valid clear issues one request with tag 1 (single stage). Its mode is {0, address-valid, process-ID-valid}, so the guest ID is ignored.
- R8: `req_addr` equals dw1 shifted left by 2, truncated to 64 bits, with its low `PAGE_SHIFT` bits cleared.
- R9: The guest ID is dw0[44 +: GSCID_W] and the process ID is dw0[12 +: PSCID_W]. With `ZERO_UNUSED` set, any ID or address that the mode does not select is driven as zero.
- R10: While a request waits with `req_ready` low, it stays valid and unchanged and `cmd_ready` stays low. `cmd_ready` rises only in the cycle in which the final request is accepted.
- R11: After reset, and whenever `cmd_valid` is low, `req_valid`, `cmd_ready`, `illegal` and `other_op` are all low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cmd_valid | input | 1 | A command is offered |
| cmd_ready | output | 1 | The command is consumed this cycle |
| cmd_dw0 | input | 64 | First command dword (opcode, function, flags, IDs) |
| cmd_dw1 | input | 64 | Second command dword (address source) |
| other_op | output | 1 | The offered command has a different opcode |
| illegal | output | 1 | The offered invalidation command is malformed |
| req_valid | output | 1 | An invalidation request is offered to the cache |
| req_ready | input | 1 | The cache accepts the request |
| req_mode | output | 3 | Match mode {guest ID, address, process ID} |
| req_tag | output | 2 | Translation tag: 0 bypass, 1 single, 2 guest-only, 3 nested |
| req_gscid | output | GSCID_W | Guest context ID |
| req_pscid | output | PSCID_W | Process context ID |
| req_addr | output | 64 | Page-aligned invalidation address |

## Verification
The bench builds the block with its defaults: 4 KiB pages, a 16-bit guest ID, a 20-bit process ID and zeroing of unused fields. With 4 KiB pages, small dw1 values with low bits set show the shift-and-mask directly. The top two bits of dw1 are used to confirm they are shifted out. The 20-bit process ID ends just below the process-ID-valid flag, so a full-width ID tests the field boundary against the flag. Zeroing makes every ignored guest ID visible at the ports. The bench can therefore check that a virtual-address command with guest-valid clear does not leak its guest ID.

// File: rtl/tlbinv_pkg.sv
package tlbinv_pkg;
   localparam int OPC_W      = 7;
   localparam int FUNC_LSB   = 7;
   localparam int FUNC_W     = 3;
   localparam int AV_BIT     = 10;
   localparam int PSCID_LSB  = 12;
   localparam int PSCV_BIT   = 32;
   localparam int GV_BIT     = 33;
   localparam int GSCID_LSB  = 44;
   localparam int MODE_W     = 3;

   localparam logic [FUNC_W-1:0] FN_VADDR = 3'd0;
   localparam logic [FUNC_W-1:0] FN_GPHYS = 3'd1;

   typedef enum logic [1:0] {
      TAG_BYPASS = 2'd0,
      TAG_SINGLE = 2'd1,
      TAG_GONLY  = 2'd2,
      TAG_NESTED = 2'd3
   } tag_e;
endpackage

// File: rtl/tlbinv_classify.sv
module tlbinv_classify
   import tlbinv_pkg::*;
#(
   parameter int                INV_OPCODE = 1,
   parameter int                GSCID_W    = 16,
   parameter int                PSCID_W    = 20,
   parameter int                PAGE_SHIFT = 12
) (
   input  logic [63:0]          dw0,
   input  logic [63:0]          dw1,
   output logic                 mine,
   output logic                 legal,
   output logic                 two_beat,
   output logic [MODE_W-1:0]    mode,
   output tag_e                 tag_first,
   output tag_e                 tag_last,
   output logic [GSCID_W-1:0]   gscid,
   output logic [PSCID_W-1:0]   pscid,
   output logic [63:0]          addr
);
   localparam logic [63:0] PAGE_MASK = ~((64'd1 << PAGE_SHIFT) - 64'd1);

   logic [FUNC_W-1:0] fn;
   logic              gv, av, pscv, is_gphys, is_vaddr;

   assign fn       = dw0[FUNC_LSB +: FUNC_W];
   assign gv       = dw0[GV_BIT];
   assign av       = dw0[AV_BIT];
   assign pscv     = dw0[PSCV_BIT];
   assign is_gphys = (fn == FN_GPHYS);
   assign is_vaddr = (fn == FN_VADDR);

   assign mine     = (dw0[OPC_W-1:0] == OPC_W'(INV_OPCODE));
   assign legal    = is_vaddr | (is_gphys & ~pscv);
   assign two_beat = is_gphys;

   always_comb begin
      if (is_gphys) begin
         mode      = {gv, gv & av, 1'b0};
         tag_first = TAG_GONLY;
         tag_last  = TAG_NESTED;
      end else begin
         mode      = {gv, av, pscv};
         tag_first = gv ? TAG_NESTED : TAG_SINGLE;
         tag_last  = tag_first;
      end
   end

   assign gscid = dw0[GSCID_LSB +: GSCID_W];
   assign pscid = dw0[PSCID_LSB +: PSCID_W];
   assign addr  = {dw1[61:0], 2'b00} & PAGE_MASK;

   logic unused_hi;
   assign unused_hi = ^dw1[63:62];
endmodule

// File: rtl/tlbinv_seq.sv
module tlbinv_seq (
   input  logic clk,
   input  logic rst_n,
   input  logic cmd_valid,
   input  logic mine,
   input  logic legal,
   input  logic two_beat,
   input  logic req_ready,
   output logic req_valid,
   output logic cmd_ready,
   output logic illegal,
   output logic other_op,
   output logic second
);
   logic second_q, active, last;

   assign active    = cmd_valid & mine & legal;
   assign last      = ~two_beat | second_q;
   assign req_valid = active;
   assign illegal   = cmd_valid & mine & ~legal;
   assign other_op  = cmd_valid & ~mine;
   assign cmd_ready = other_op | illegal | (active & req_ready & last);
   assign second    = second_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         second_q <= 1'b0;
      else if (active & req_ready)
         second_q <= ~last;
   end
endmodule

// File: rtl/tlbinv_fieldgate.sv
module tlbinv_fieldgate
   import tlbinv_pkg::*;
#(
   parameter int GSCID_W     = 16,
   parameter int PSCID_W     = 20,
   parameter bit ZERO_UNUSED = 1'b1
) (
   input  logic [MODE_W-1:0]  mode,
   input  logic [GSCID_W-1:0] gscid_in,
   input  logic [PSCID_W-1:0] pscid_in,
   input  logic [63:0]        addr_in,
   output logic [GSCID_W-1:0] gscid_out,
   output logic [PSCID_W-1:0] pscid_out,
   output logic [63:0]        addr_out
);
   generate
      if (ZERO_UNUSED) begin : g_zero
         assign gscid_out = mode[2] ? gscid_in : '0;
         assign addr_out  = mode[1] ? addr_in  : '0;
         assign pscid_out = mode[0] ? pscid_in : '0;
      end else begin : g_raw
         logic unused_mode;
         assign unused_mode = ^mode;
         assign gscid_out   = gscid_in;
         assign addr_out    = addr_in;
         assign pscid_out   = pscid_in;
      end
   endgenerate
endmodule

// File: rtl/tlbinv_cmd_decoder.sv
module tlbinv_cmd_decoder
   import tlbinv_pkg::*;
#(
   parameter int INV_OPCODE  = 1,
   parameter int GSCID_W     = 16,
   parameter int PSCID_W     = 20,
   parameter int PAGE_SHIFT  = 12,
   parameter bit ZERO_UNUSED = 1'b1
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               cmd_valid,
   output logic               cmd_ready,
   input  logic [63:0]        cmd_dw0,
   input  logic [63:0]        cmd_dw1,
   output logic               other_op,
   output logic               illegal,
   output logic               req_valid,
   input  logic               req_ready,
   output logic [2:0]         req_mode,
   output logic [1:0]         req_tag,
   output logic [GSCID_W-1:0] req_gscid,
   output logic [PSCID_W-1:0] req_pscid,
   output logic [63:0]        req_addr
);
   initial begin
      assert (PSCID_LSB + PSCID_W <= PSCV_BIT)
         else $error("process ID field overlaps the flag bits");
      assert (GSCID_LSB + GSCID_W <= 64)
         else $error("guest ID field exceeds dw0");
      assert (PAGE_SHIFT >= 2 && PAGE_SHIFT < 64)
         else $error("page shift out of range");
      assert (INV_OPCODE >= 0 && INV_OPCODE < (1 << OPC_W))
         else $error("opcode does not fit");
   end

   logic               mine, legal, two_beat, second;
   logic [MODE_W-1:0]  mode;
   tag_e               tag_first, tag_last;
   logic [GSCID_W-1:0] gscid;
   logic [PSCID_W-1:0] pscid;
   logic [63:0]        addr;

   tlbinv_classify #(
      .INV_OPCODE (INV_OPCODE),
      .GSCID_W    (GSCID_W),
      .PSCID_W    (PSCID_W),
      .PAGE_SHIFT (PAGE_SHIFT)
   ) u_classify (
      .dw0       (cmd_dw0),
      .dw1       (cmd_dw1),
      .mine      (mine),
      .legal     (legal),
      .two_beat  (two_beat),
      .mode      (mode),
      .tag_first (tag_first),
      .tag_last  (tag_last),
      .gscid     (gscid),
      .pscid     (pscid),
      .addr      (addr)
   );

   tlbinv_seq u_seq (
      .clk       (clk),
      .rst_n     (rst_n),
      .cmd_valid (cmd_valid),
      .mine      (mine),
      .legal     (legal),
      .two_beat  (two_beat),
      .req_ready (req_ready),
      .req_valid (req_valid),
      .cmd_ready (cmd_ready),
      .illegal   (illegal),
      .other_op  (other_op),
      .second    (second)
   );

   tlbinv_fieldgate #(
      .GSCID_W     (GSCID_W),
      .PSCID_W     (PSCID_W),
      .ZERO_UNUSED (ZERO_UNUSED)
   ) u_gate (
      .mode      (mode),
      .gscid_in  (gscid),
      .pscid_in  (pscid),
      .addr_in   (addr),
      .gscid_out (req_gscid),
      .pscid_out (req_pscid),
      .addr_out  (req_addr)
   );

   assign req_mode = mode;
   assign req_tag  = second ? tag_last : tag_first;
endmodule

// File: rtl/tlbinv_cmd_decoder_chk.sv
module tlbinv_cmd_decoder_chk #(
   parameter int PAGE_SHIFT = 12
) (
   input logic        clk,
   input logic        rst_n,
   input logic        cmd_valid,
   input logic        cmd_ready,
   input logic        other_op,
   input logic        illegal,
   input logic        req_valid,
   input logic        req_ready,
   input logic [2:0]  req_mode,
   input logic [1:0]  req_tag,
   input logic [63:0] req_addr
);
   p_other_r1: assert property (@(posedge clk) disable iff (!rst_n)
      other_op |-> (cmd_ready && !req_valid && !illegal));

   p_illegal_r3: assert property (@(posedge clk) disable iff (!rst_n)
      illegal |-> (cmd_ready && !req_valid));

   p_pair_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (req_valid && req_ready && req_tag == 2'd2) |=> (req_valid && req_tag == 2'd3));

   p_tag_r6: assert property (@(posedge clk) disable iff (!rst_n)
      req_valid |-> (req_tag != 2'd0));

   p_align_r8: assert property (@(posedge clk) disable iff (!rst_n)
      req_valid |-> (req_addr[PAGE_SHIFT-1:0] == '0));

   p_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
      (req_valid && !req_ready) |=>
         (req_valid && $stable(req_tag) && $stable(req_mode) && $stable(req_addr)));

   p_ready_r10: assert property (@(posedge clk) disable iff (!rst_n)
      (cmd_ready && req_valid) |-> req_ready);

   p_idle_r11: assert property (@(posedge clk) disable iff (!rst_n)
      !cmd_valid |-> (!req_valid && !cmd_ready && !illegal && !other_op));
endmodule

bind tlbinv_cmd_decoder tlbinv_cmd_decoder_chk #(.PAGE_SHIFT(PAGE_SHIFT)) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .cmd_valid (cmd_valid),
   .cmd_ready (cmd_ready),
   .other_op  (other_op),
   .illegal   (illegal),
   .req_valid (req_valid),
   .req_ready (req_ready),
   .req_mode  (req_mode),
   .req_tag   (req_tag),
   .req_addr  (req_addr)
);

// File: tb/tlbinv_cmd_decoder_test.sv
`timescale 1ns/1ps
module tlbinv_cmd_decoder_test;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        cmd_valid = 1'b0;
   logic        cmd_ready;
   logic [63:0] cmd_dw0 = '0;
   logic [63:0] cmd_dw1 = '0;
   logic        other_op, illegal, req_valid;
   logic        req_ready = 1'b0;
   logic [2:0]  req_mode;
   logic [1:0]  req_tag;
   logic [15:0] req_gscid;
   logic [19:0] req_pscid;
   logic [63:0] req_addr;

   int vectors = 0;
   int misses  = 0;
   int cycles  = 0;

   always #2.5 clk = ~clk;

   tlbinv_cmd_decoder uut (
      .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_ready(cmd_ready),
      .cmd_dw0(cmd_dw0), .cmd_dw1(cmd_dw1), .other_op(other_op), .illegal(illegal),
      .req_valid(req_valid), .req_ready(req_ready), .req_mode(req_mode),
      .req_tag(req_tag), .req_gscid(req_gscid), .req_pscid(req_pscid),
      .req_addr(req_addr)
   );

   typedef struct {
      logic [2:0]  m;
      logic [1:0]  t;
      logic [15:0] g;
      logic [19:0] p;
      logic [63:0] a;
   } exp_t;

   exp_t q[$];

   task automatic chk(input string rq, input logic [63:0] act, input logic [63:0] exp);
      vectors++;
      if (act !== exp) begin
         misses++;
         $display("FAIL %s actual=%h expected=%h", rq, act, exp);
      end
   endtask

   function automatic logic [63:0] mk(input int opc, input int fn, input bit gv,
                                      input bit av, input bit pscv,
                                      input logic [15:0] g, input logic [19:0] p);
      logic [63:0] d = '0;
      d[6:0]   = opc[6:0];
      d[9:7]   = fn[2:0];
      d[10]    = av;
      d[31:12] = p;
      d[32]    = pscv;
      d[33]    = gv;
      d[59:44] = g;
      return d;
   endfunction

   task automatic check_idle(input string rq);
      chk({rq, " req_valid"}, 64'(req_valid), 64'd0);
      chk({rq, " cmd_ready"}, 64'(cmd_ready), 64'd0);
      chk({rq, " illegal"},   64'(illegal),   64'd0);
      chk({rq, " other_op"},  64'(other_op),  64'd0);
   endtask

   task automatic run_cmd(input logic [63:0] d0, input logic [63:0] d1, input int stall);
      bit          ex_other, ex_ill;
      string       rq;
      logic [2:0]  m;
      logic [63:0] a;
      exp_t        e;
      int          cyc;
      bit          rdy, done;
      ex_other = 0; ex_ill = 0; rq = "R1";
      q.delete();
      a = (d1 << 2) & ~64'hFFF;
      if (d0[6:0] != 7'd1) begin
         ex_other = 1; rq = "R1";
      end else if (d0[9:7] == 3'd1) begin
         if (d0[32]) begin
            ex_ill = 1; rq = "R3";
         end else begin
            rq = "R4/R5";
            m = d0[33] ? (d0[10] ? 3'd6 : 3'd4) : 3'd0;
            e.m = m; e.g = m[2] ? d0[59:44] : 16'd0;
            e.p = 20'd0; e.a = m[1] ? a : 64'd0;
            e.t = 2'd2; q.push_back(e);
            e.t = 2'd3; q.push_back(e);
         end
      end else if (d0[9:7] == 3'd0) begin
         rq = d0[33] ? "R6" : "R7";
         m = {d0[33], d0[10], d0[32]};
         e.m = m; e.t = d0[33] ? 2'd3 : 2'd1;
         e.g = m[2] ? d0[59:44] : 16'd0;
         e.p = m[0] ? d0[31:12] : 20'd0;
         e.a = m[1] ? a : 64'd0;
         q.push_back(e);
      end else begin
         ex_ill = 1; rq = "R2";
      end

      cmd_dw0 = d0; cmd_dw1 = d1; cmd_valid = 1'b1;
      cyc = 0; done = 0;
      while (!done && cyc < 40) begin
         rdy = (cyc >= stall) ? (((cyc + stall) % 3) != 1) : 1'b0;
         req_ready = rdy;
         @(negedge clk);
         chk({rq, " other_op"}, 64'(other_op), 64'(ex_other));
         chk({rq, " illegal"},  64'(illegal),  64'(ex_ill));
         chk({"R10 req_valid"}, 64'(req_valid), 64'(q.size() > 0));
         if (q.size() > 0) begin
            chk({rq, " mode"},    64'(req_mode),  64'(q[0].m));
            chk({rq, " tag"},     64'(req_tag),   64'(q[0].t));
            chk("R9 gscid",       64'(req_gscid), 64'(q[0].g));
            chk("R9 pscid",       64'(req_pscid), 64'(q[0].p));
            chk("R8 addr",        req_addr,       q[0].a);
            chk("R10 cmd_ready",  64'(cmd_ready), 64'(q.size() == 1 && rdy));
            done = (q.size() == 1 && rdy);
         end else begin
            chk({rq, " cmd_ready"}, 64'(cmd_ready), 64'd1);
            done = 1;
         end
         @(posedge clk);
         #1;
         if (q.size() > 0 && rdy) void'(q.pop_front());
         cyc++;
      end
      if (!done) chk("R10 command never consumed", 64'd0, 64'd1);
      cmd_valid = 1'b0; req_ready = 1'b0;
      @(negedge clk);
      check_idle("R11 after command");
      @(posedge clk);
      #1;
   endtask

   always @(posedge clk) begin
      cycles++;
      if (cycles > 20000) begin
         misses++;
         $display("FAIL watchdog expired");
         $display("== %0d vectors applied, %0d miscompares ==", vectors, misses);
         $finish;
      end
   end

   initial begin
      repeat (3) @(posedge clk);
      #1;
      @(negedge clk);
      check_idle("R11 in reset");
      rst_n = 1'b1;
      @(posedge clk);
      #1;
      @(negedge clk);
      check_idle("R11 after reset");
      @(posedge clk);
      #1;

      // R6/R7: every flag combination of the virtual-address function
      for (int k = 0; k < 8; k++) begin
         run_cmd(mk(1, 0, k[2], k[1], k[0], 16'hA5C3, 20'hFFFFF),
                 64'hC000_0000_0123_4567, k % 3);
      end
      // R4/R5: legal guest-physical combinations, including AV ignored with GV clear
      for (int k = 0; k < 4; k++) begin
         run_cmd(mk(1, 1, k[1], k[0], 1'b0, 16'h1234, 20'h0BEEF),
                 64'h0000_0000_0000_0FFF + 64'(k), k);
      end
      // R3: guest-physical with process-ID-valid set
      run_cmd(mk(1, 1, 1'b1, 1'b1, 1'b1, 16'h7, 20'h9), 64'h10, 0);
      run_cmd(mk(1, 1, 1'b0, 1'b0, 1'b1, 16'h7, 20'h9), 64'h10, 2);
      // R2: unused function codes
      run_cmd(mk(1, 5, 1'b1, 1'b0, 1'b0, 16'h7, 20'h9), 64'h10, 0);
      run_cmd(mk(1, 2, 1'b0, 1'b1, 1'b0, 16'h7, 20'h9), 64'h10, 0);
      // R1: other opcodes pass through
      run_cmd(mk(2, 1, 1'b1, 1'b1, 1'b0, 16'h7, 20'h9), 64'h10, 0);
      run_cmd(mk(0, 0, 1'b1, 1'b1, 1'b1, 16'h7, 20'h9), 64'h10, 1);
      // R8: high address bits shifted out, long stall for R10
      run_cmd(mk(1, 0, 1'b0, 1'b1, 1'b0, 16'hFFFF, 20'h1), 64'hFFFF_FFFF_FFFF_FFFF, 5);
      run_cmd(mk(1, 1, 1'b1, 1'b1, 1'b0, 16'hFFFF, 20'hFFFFF), 64'h4000_0000_0000_0400, 4);

      $display("== %0d vectors applied, %0d miscompares ==", vectors, misses);
      $finish;
   end
endmodule